// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block gives a host bus a byte-wide view of a standard parallel printer port: a data register, a status register and a control register. No printer is attached. The printer's busy and acknowledge handshake is modelled inside the status register, so driver software sees the same sequence of status bits it would see from a real printer.

When software raises the strobe bit in the control register, the latched data byte leaves the block on a one-cycle valid/byte output. When software lowers the strobe bit with interrupt enable set, a level interrupt is raised. Reading status clears that interrupt.

Input data for reads in the input direction comes from an external byte input. The block decodes only the low address bits, so the register set repeats through the whole address range.

Top module: `prn_port_regs`

## Requirements
- R1: Only the low 3 address bits are decoded. Offset 0 is data, 1 is status and 2 is control. A read from offsets 3 to 7 returns 0xFF. A write to offsets 1 or 3 to 7 changes no register.
- R2: After reset the written data byte is 0xFF, status is 0xD9, control is 0xCC, the interrupt is low, the byte output valid is low and the read data output is 0xFF.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. A control read returns the stored value. Control bit positions: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init (0 = initialise), 1 auto linefeed, 0 strobe.
- R4: A control write with bit 2 = 0 loads status with 0xD8. Status bit positions: 7 not-busy, 6 acknowledge, 5 paper out, 4 online, 3 not-error, 0 timeout.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 1 clears status bit 7. If the stored control bit 0 was 0 before that write, the data byte is also emitted: valid is high for exactly one clock, starting after that write's edge, with the byte on the output.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 makes the interrupt pending if the stored control bit 4 (before the write) is 1. The interrupt output goes high after that edge and stays high until a status read.
- R7: A status read returns the current status and clears the pending interrupt. Then, if status bit 7 is 0 and the stored control bit 0 is 0, a set bit 6 is cleared; if bit 6 was already clear, bits 6 and 7 are both set.
- R8: A data read returns the external input byte when control bit 5 is 1. Otherwise it returns the last byte written to offset 0.
- R9: Read data is registered. It appears after the edge where the read is sampled, and it holds until the next accepted read.
- R10: In a cycle with both write and read requested, the write is performed and the read is ignored: read data holds and a status read's side effects do not happen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address; only the low DEC_W bits are decoded |
| bus_wr | input | 1 | Write request, sampled on the rising edge |
| bus_rd | input | 1 | Read request, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_din | input | 8 | External byte returned by data reads in the input direction |
| tx_valid | output | 1 | One-cycle pulse marking an emitted byte |
| tx_byte | output | 8 | Emitted byte, valid while tx_valid is high |
| irq | output | 1 | Registered level interrupt, high while an interrupt is pending |

## Verification
The embedded assertions check, on every cycle, the properties that can be stated locally. The emit pulse never lasts two cycles and always coincides with a cleared not-busy bit. A status read always leaves the interrupt low, and the interrupt only rises after a control write. An init-low control write always yields 0xD8 in status, a read of an unused offset always yields 0xFF, and read data holds through a collision between read and write. Whether the acknowledge and busy bits step in the right order across successive status reads, and whether data reads follow the direction bit, depends on history. Only the bench's scenarios show those: they compare each read, emit and interrupt level against a reference model built from the requirements, under random and directed traffic.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned BYTE_W = 8;

  // status bit positions
  localparam int unsigned ST_NBUSY = 7;
  localparam int unsigned ST_ACK   = 6;

  // control bit positions
  localparam int unsigned CT_DIR   = 5;
  localparam int unsigned CT_IEN   = 4;
  localparam int unsigned CT_SEL   = 3;
  localparam int unsigned CT_NINIT = 2;
  localparam int unsigned CT_STB   = 0;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] OPEN_READ  = 8'hFF;
endpackage

// File: rtl/pp_status.sv
module pp_status
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_new,
  input  logic [BYTE_W-1:0] ctl_old,
  input  logic              st_rd,
  output logic [BYTE_W-1:0] status_q,
  output logic              pend_q,
  output logic              emit
);
  logic hs_active;
  assign hs_active = ctl_new[CT_NINIT] && ctl_new[CT_SEL];
  assign emit = ctl_wr && hs_active && ctl_new[CT_STB] && !ctl_old[CT_STB];

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= STAT_RST;
      pend_q   <= 1'b0;
    end else if (ctl_wr) begin
      if (!ctl_new[CT_NINIT]) begin
        status_q <= STAT_INIT;
      end else if (ctl_new[CT_SEL]) begin
        if (ctl_new[CT_STB]) status_q[ST_NBUSY] <= 1'b0;
        else if (ctl_old[CT_IEN]) pend_q <= 1'b1;
      end
    end else if (st_rd) begin
      pend_q <= 1'b0;
      if (!status_q[ST_NBUSY] && !ctl_old[CT_STB]) begin
        if (status_q[ST_ACK]) begin
          status_q[ST_ACK] <= 1'b0;
        end else begin
          status_q[ST_ACK]   <= 1'b1;
          status_q[ST_NBUSY] <= 1'b1;
        end
      end
    end
  end

  // R4
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_new[CT_NINIT]) |=> (status_q == STAT_INIT));

  // R7
  rd_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> !pend_q);
endmodule

// File: rtl/pp_emit.sv
module pp_emit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] byte_in,
  output logic         tx_valid,
  output logic [W-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= fire;
      if (fire) tx_byte <= byte_in;
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import pp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] ext_din,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  localparam logic [DEC_W-1:0] OFS_DATA = DEC_W'(0);
  localparam logic [DEC_W-1:0] OFS_STAT = DEC_W'(1);
  localparam logic [DEC_W-1:0] OFS_CTRL = DEC_W'(2);

  logic [DEC_W-1:0]  sel;
  logic              rd_ok, wr_data, wr_ctl, st_rd, emit, pend_q;
  logic [BYTE_W-1:0] dataw_q, ctrl_q, ctl_new, status_q, rd_mux;

  assign sel     = bus_addr[DEC_W-1:0];
  assign rd_ok   = bus_rd && !bus_wr;
  assign wr_data = bus_wr && (sel == OFS_DATA);
  assign wr_ctl  = bus_wr && (sel == OFS_CTRL);
  assign st_rd   = rd_ok && (sel == OFS_STAT);
  assign ctl_new = bus_wdata | CTRL_FORCE;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataw_q <= DATA_RST;
      ctrl_q  <= CTRL_RST;
    end else begin
      if (wr_data) dataw_q <= bus_wdata;
      if (wr_ctl)  ctrl_q  <= ctl_new;
    end
  end

  always_comb begin
    case (sel)
      OFS_DATA: rd_mux = ctrl_q[CT_DIR] ? ext_din : dataw_q;
      OFS_STAT: rd_mux = status_q;
      OFS_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = OPEN_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= OPEN_READ;
    else if (rd_ok) bus_rdata <= rd_mux;
  end

  pp_status u_status (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (wr_ctl),
    .ctl_new  (ctl_new),
    .ctl_old  (ctrl_q),
    .st_rd    (st_rd),
    .status_q (status_q),
    .pend_q   (pend_q),
    .emit     (emit)
  );

  pp_emit #(.W(BYTE_W)) u_emit (
    .clk      (clk),
    .rst      (rst),
    .fire     (emit),
    .byte_in  (dataw_q),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte)
  );

  assign irq = pend_q;

  // R5
  emit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !status_q[ST_NBUSY]);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_ctl));

  // R10
  collide_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));

  // R1
  open_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && (sel > OFS_CTRL)) |=> (bus_rdata == OPEN_READ));
endmodule

// File: tb/prn_port_regs_tb.sv
module prn_port_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, ext_din = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic       tx_valid, irq;

  prn_port_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_din(ext_din),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_dataw, m_stat, m_ctrl, m_rdata;
  logic       m_pend;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model of a control write, returns 1 when a byte must be emitted
  function automatic bit model_ctl(logic [7:0] d);
    logic [7:0] v;
    bit e;
    e = 0;
    v = d | 8'hC0;
    if (!v[2]) m_stat = 8'hD8;
    else if (v[3]) begin
      if (v[0]) begin
        m_stat[7] = 1'b0;
        if (!m_ctrl[0]) e = 1;
      end else if (m_ctrl[4]) m_pend = 1'b1;
    end
    m_ctrl = v;
    return e;
  endfunction

  function automatic logic [7:0] model_rd(logic [2:0] o, logic [7:0] din);
    logic [7:0] r;
    case (o)
      3'd0: r = m_ctrl[5] ? din : m_dataw;
      3'd1: begin
        r = m_stat;
        m_pend = 1'b0;
        if (!m_stat[7] && !m_ctrl[0]) begin
          if (m_stat[6]) m_stat[6] = 1'b0;
          else begin m_stat[6] = 1'b1; m_stat[7] = 1'b1; end
        end
      end
      3'd2: r = m_ctrl;
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

  task automatic do_wr(logic [7:0] a, logic [7:0] d);
    bit e;
    logic [7:0] eb;
    e = 0;
    eb = m_dataw;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a[2:0] == 3'd0) m_dataw = d;
    else if (a[2:0] == 3'd2) e = model_ctl(d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R5 tx_valid", {7'd0, tx_valid}, {7'd0, e});
    if (e) chk("R5 tx_byte", tx_byte, eb);
    chk("R6 irq", {7'd0, irq}, {7'd0, m_pend});
    chk("R9 rdata hold on write", bus_rdata, m_rdata);
  endtask

  task automatic do_rd(logic [7:0] a, logic [7:0] din);
    string tag;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; ext_din = din;
    m_rdata = model_rd(a[2:0], din);
    case (a[2:0])
      3'd0: tag = "R8 data read";
      3'd1: tag = "R7 status read";
      3'd2: tag = "R3 control read";
      default: tag = "R1 open read";
    endcase
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, m_rdata);
    chk("R7 irq after read", {7'd0, irq}, {7'd0, m_pend});
  endtask

  task automatic do_both(logic [7:0] a, logic [7:0] d);
    bit e;
    e = 0;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
    if (a[2:0] == 3'd0) m_dataw = d;
    else if (a[2:0] == 3'd2) e = model_ctl(d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 rdata held", bus_rdata, m_rdata);
    chk("R10 irq", {7'd0, irq}, {7'd0, m_pend});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_dataw = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC; m_pend = 0; m_rdata = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R2 reset state
    chk("R2 rdata", bus_rdata, 8'hFF);
    chk("R2 irq", {7'd0, irq}, 8'd0);
    chk("R2 tx_valid", {7'd0, tx_valid}, 8'd0);
    do_rd(8'h01, 8'h00);
    chk("R2 status", m_rdata, 8'hD9);
    do_rd(8'h02, 8'h00);
    chk("R2 control", m_rdata, 8'hCC);
    do_rd(8'h00, 8'h12);
    chk("R2 data", bus_rdata, 8'hFF);

    // R4 init low
    do_wr(8'h02, 8'h00);
    do_rd(8'h01, 8'h00);
    chk("R4 status after init", bus_rdata, 8'hD8);
    do_rd(8'h02, 8'h00);
    chk("R3 forced bits", bus_rdata, 8'hC0);

    // handshake sequence
    do_wr(8'h00, 8'h5A);
    do_wr(8'h02, 8'h1C);
    chk("R6 no irq without stored enable", {7'd0, irq}, 8'd0);
    do_wr(8'h02, 8'h1D);
    do_wr(8'h02, 8'h1C);
    chk("R6 irq raised", {7'd0, irq}, 8'd1);
    do_rd(8'h01, 8'h00);
    chk("R7 first read", bus_rdata, 8'h58);
    do_rd(8'h01, 8'h00);
    chk("R7 second read", bus_rdata, 8'h18);
    do_rd(8'h01, 8'h00);
    chk("R7 third read", bus_rdata, 8'hD8);

    // R1 writes to unused offsets and aliases
    do_wr(8'h01, 8'h00);
    do_wr(8'h07, 8'h00);
    do_rd(8'h01, 8'h00);
    chk("R1 status untouched", bus_rdata, 8'hD8);
    do_wr(8'hFA, 8'h2C);
    do_rd(8'hF8, 8'h3C);
    chk("R8 input direction", bus_rdata, 8'h3C);

    // R9 hold while idle
    repeat (3) @(negedge clk);
    chk("R9 rdata idle hold", bus_rdata, 8'h3C);

    // R10 collision
    do_both(8'h02, 8'h0C);
    do_both(8'h00, 8'h77);
    do_rd(8'h00, 8'hAA);
    chk("R10 write performed", bus_rdata, 8'h77);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, d;
      int k;
      k = int'($urandom_range(0, 9));
      a = 8'($urandom);
      d = 8'($urandom);
      if (k < 4) begin
        a[2:0] = 3'd2;
        if ($urandom_range(0, 7) != 0) d[2] = 1'b1;
        if ($urandom_range(0, 7) != 0) d[3] = 1'b1;
        do_wr(a, d);
      end else if (k < 5) begin
        do_wr(a, d);
      end else if (k < 8) begin
        a[2:0] = 3'd1;
        do_rd(a, d);
      end else if (k < 9) begin
        do_rd(a, d);
      end else begin
        do_both(a, d);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule